// File: doc/BRIEF.md
# Programmable-Rate Memory Scrubber

This block walks a chosen window of error-protected SRAM in the background. It reads one word at a time through a single-error-correct / double-error-detect (SECDED) decoder. Each read comes at a pace set in a register. When the decoder repairs a single-bit fault, the scrubber re-encodes the repaired data and writes it back, so that the fault does not grow into an uncorrectable double fault. When the decoder finds a word beyond repair, the scrubber counts it and raises a one-cycle alert, and it leaves the word untouched.

The scrubber shares the SRAM port with the processor and always yields to it. A read or write-back that the processor blocks stays pending until the port is free. A processor write to the word being scrubbed cancels the write-back, so stale repaired data never overwrites new data. Software programs the enable, the pace, the window base and the window length through a small write-only register port. The corrected-word and uncorrectable-word counts are output pins.

Top module: `mem_scrub_engine`

## Requirements
- R1: After reset the memory port is idle, both counts are zero, the alert is low, and scrubbing is disabled. The pace, base and length reset to zero.
- R2: A register write takes effect in the next cycle. The select codes are 0 for control (bit 0 is the enable), 1 for the pace in cycles, 2 for the window base and 3 for the window length in words. A pace of 0 behaves as a pace of 1, and a length of 0 behaves as a length of 1.
- R3: While enabled and free of processor traffic and errors, one scrub read is issued every pace+2 cycles. After a step finishes, the scrubber waits pace cycles before it requests the next read.
- R4: Scrub reads visit base, base+1, … base+length−1 and then return to base. The address starts at base after reset.
- R5: A processor request always owns the memory port unchanged. A scrub read or write-back that the processor blocks is retried in a later free cycle and is never dropped.
- R6: A codeword holds the data bits at the non-power-of-two positions 1..N in ascending order. Each power-of-two position 2^i carries the even parity of all positions with bit i set. Bit 0 carries the even parity of the whole word. When the word read back has a correctable single error (the overall parity is wrong and the syndrome is at most N, where a syndrome of 0 means bit 0 itself), the corrected count rises by one. The re-encoded data is then written back in the first free cycle after the read data returns.
- R7: A word that decodes with no error is never written back.
- R8: An uncorrectable word is either a syndrome other than 0 with correct overall parity, or a syndrome above N. Such a word is not written back, the uncorrectable count rises by one, and the alert is high for exactly the cycle after the read data returns.
- R9: A processor write to the address being scrubbed, in the cycle the read data returns or while the write-back waits, cancels the write-back.
- R10: Both counts saturate at their all-ones value.
- R11: Clearing the enable stops new steps, but a step that has already begun (including a read stalled by the processor) runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | IW | Register write data |
| cpu_req | input | 1 | Processor memory request |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | CW | Processor write codeword |
| mem_req | output | 1 | SRAM request |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | AW | SRAM word address |
| mem_wdata | output | CW | SRAM write codeword |
| mem_rdata | input | CW | SRAM read codeword, valid the cycle after a read |
| corr_count | output | CNTW | Saturating count of corrected words |
| unc_count | output | CNTW | Saturating count of uncorrectable words |
| unc_alert | output | 1 | One-cycle pulse per uncorrectable word |

## Verification
A wrong step state or pace counter shows on the memory port within one pace period: a scrub read is missing, comes early, or carries the wrong address, and the per-clock comparison against the bench model flags it in that cycle. A corrupted offset shows on the next scrub read as a wrong address. A lost pending write-back or a spurious one shows as a wrong write strobe in the first free port cycle after the read data returns. A decode slip shows in the same cycle as a wrong count or a wrong alert, or later as an SRAM word that does not hold its expected value.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WAIT = 2'd2,
        ST_WB   = 2'd3
    } scrub_st_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_PACE = 2'd1;
    localparam logic [1:0] SEL_BASE = 2'd2;
    localparam logic [1:0] SEL_SPAN = 2'd3;

    // number of Hamming check bits needed for dw data bits
    function automatic int secded_pw(int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    // full codeword width including the overall parity bit
    function automatic int secded_cw(int dw);
        return dw + secded_pw(dw) + 1;
    endfunction

endpackage

// File: rtl/scrub_secded.sv
module scrub_secded #(
    parameter  int DW = 16,
    localparam int PW = scrub_pkg::secded_pw(DW),
    localparam int NP = DW + PW,
    localparam int CW = NP + 1
) (
    input  logic [DW-1:0] enc_data,
    output logic [CW-1:0] enc_cw,
    input  logic [CW-1:0] dec_cw,
    output logic [DW-1:0] dec_data,
    output logic          dec_single,
    output logic          dec_double
);

    // encoder: data at non-power-of-two positions, check bits at 2^i
    always_comb begin : encode
        logic [CW-1:0] w;
        int di;
        w  = '0;
        di = 0;
        for (int k = 1; k <= NP; k++) begin
            if ((k & (k - 1)) != 0) begin
                w[k] = enc_data[di];
                di++;
            end
        end
        for (int i = 0; i < PW; i++) begin
            logic p;
            p = 1'b0;
            for (int k = 1; k <= NP; k++) begin
                if (k[i]) p = p ^ w[k];
            end
            w[1 << i] = p;
        end
        w[0] = ^w[CW-1:1];
        enc_cw = w;
    end

    // decoder: syndrome plus overall parity classify the word
    always_comb begin : decode
        logic [PW-1:0] syn;
        logic          ov;
        logic [CW-1:0] fx;
        int            di;
        syn = '0;
        for (int i = 0; i < PW; i++) begin
            for (int k = 1; k <= NP; k++) begin
                if (k[i]) syn[i] = syn[i] ^ dec_cw[k];
            end
        end
        ov         = ^dec_cw;
        fx         = dec_cw;
        dec_single = 1'b0;
        dec_double = 1'b0;
        if (ov) begin
            if (int'(syn) <= NP) begin
                dec_single = 1'b1;
                fx[syn]    = ~fx[syn];
            end else begin
                dec_double = 1'b1;
            end
        end else if (syn != '0) begin
            dec_double = 1'b1;
        end
        dec_data = '0;
        di       = 0;
        for (int k = 1; k <= NP; k++) begin
            if ((k & (k - 1)) != 0) begin
                dec_data[di] = fx[k];
                di++;
            end
        end
    end

endmodule

// File: rtl/scrub_cfg.sv
module scrub_cfg #(
    parameter int AW = 10,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [IW-1:0] reg_wdata,
    output logic          cfg_en,
    output logic [IW-1:0] cfg_pace,
    output logic [AW-1:0] cfg_base,
    output logic [AW-1:0] cfg_span
);
    import scrub_pkg::*;

    typedef struct packed {
        logic          en;
        logic [IW-1:0] pace;
        logic [AW-1:0] base;
        logic [AW-1:0] span;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_we) begin
            case (reg_sel)
                SEL_CTRL: cfg_d.en   = reg_wdata[0];
                SEL_PACE: cfg_d.pace = reg_wdata;
                SEL_BASE: cfg_d.base = reg_wdata[AW-1:0];
                SEL_SPAN: cfg_d.span = reg_wdata[AW-1:0];
                default:  cfg_d      = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_en   = cfg_q.en;
    assign cfg_pace = cfg_q.pace;
    assign cfg_base = cfg_q.base;
    assign cfg_span = cfg_q.span;

endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl #(
    parameter int DW   = 16,
    parameter int AW   = 10,
    parameter int IW   = 16,
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en,
    input  logic [IW-1:0]   cfg_pace,
    input  logic [AW-1:0]   cfg_base,
    input  logic [AW-1:0]   cfg_span,
    input  logic            cpu_req,
    input  logic            cpu_we,
    input  logic [AW-1:0]   cpu_addr,
    input  logic            rd_single,
    input  logic            rd_double,
    input  logic [DW-1:0]   rd_data,
    output logic            scrub_req,
    output logic            scrub_we,
    output logic [AW-1:0]   scrub_addr,
    output logic [DW-1:0]   wb_data,
    output logic [CNTW-1:0] corr_count,
    output logic [CNTW-1:0] unc_count,
    output logic            unc_alert
);
    import scrub_pkg::*;

    typedef struct packed {
        scrub_st_e       st;
        logic [IW-1:0]   tmr;
        logic [AW-1:0]   off;
        logic [DW-1:0]   wb;
        logic [CNTW-1:0] corr;
        logic [CNTW-1:0] unc;
        logic            alert;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IW-1:0] pace_eff;
    logic [AW-1:0] last_off;
    logic [AW-1:0] cur_addr;
    logic          cpu_hits;
    logic          step_done;

    assign pace_eff = (cfg_pace == '0) ? IW'(1) : cfg_pace;
    assign last_off = (cfg_span == '0) ? '0 : cfg_span - AW'(1);
    assign cur_addr = cfg_base + ctl_q.off;
    assign cpu_hits = cpu_req && cpu_we && (cpu_addr == cur_addr);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.alert = 1'b0;
        step_done   = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (!cfg_en) begin
                    ctl_d.tmr = '0;
                end else if (({1'b0, ctl_q.tmr} + (IW+1)'(1)) >= {1'b0, pace_eff}) begin
                    ctl_d.tmr = '0;
                    ctl_d.st  = ST_RD;
                end else begin
                    ctl_d.tmr = ctl_q.tmr + IW'(1);
                end
            end
            ST_RD: begin
                if (!cpu_req) ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rd_double) begin
                    if (ctl_q.unc != '1) ctl_d.unc = ctl_q.unc + CNTW'(1);
                    ctl_d.alert = 1'b1;
                    step_done   = 1'b1;
                end else if (rd_single) begin
                    if (ctl_q.corr != '1) ctl_d.corr = ctl_q.corr + CNTW'(1);
                    if (cpu_hits) begin
                        step_done = 1'b1;
                    end else begin
                        ctl_d.wb = rd_data;
                        ctl_d.st = ST_WB;
                    end
                end else begin
                    step_done = 1'b1;
                end
            end
            ST_WB: begin
                if (!cpu_req || cpu_hits) step_done = 1'b1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        if (step_done) begin
            ctl_d.st  = ST_IDLE;
            ctl_d.tmr = '0;
            ctl_d.off = (ctl_q.off >= last_off) ? '0 : ctl_q.off + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign scrub_req  = (ctl_q.st == ST_RD) || (ctl_q.st == ST_WB);
    assign scrub_we   = (ctl_q.st == ST_WB);
    assign scrub_addr = cur_addr;
    assign wb_data    = ctl_q.wb;
    assign corr_count = ctl_q.corr;
    assign unc_count  = ctl_q.unc;
    assign unc_alert  = ctl_q.alert;

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RD && cpu_req) |=> (ctl_q.st == ST_RD)); // R5

    AST_WB_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.st == ST_WB) |-> $past(ctl_q.st == ST_WAIT)); // R6

    AST_ALERT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.alert |=> !ctl_q.alert); // R8

    AST_CORR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.corr != $past(ctl_q.corr)) |-> (ctl_q.corr == $past(ctl_q.corr) + CNTW'(1))); // R10

    AST_UNC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.unc != $past(ctl_q.unc)) |-> (ctl_q.unc == $past(ctl_q.unc) + CNTW'(1))); // R10

    AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && !cfg_en) |=> (ctl_q.st == ST_IDLE)); // R11

endmodule

// File: rtl/mem_scrub_engine.sv
module mem_scrub_engine #(
    parameter  int DW   = 16,
    parameter  int AW   = 10,
    parameter  int IW   = 16,
    parameter  int CNTW = 16,
    localparam int CW   = scrub_pkg::secded_cw(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [1:0]      reg_sel,
    input  logic [IW-1:0]   reg_wdata,
    input  logic            cpu_req,
    input  logic            cpu_we,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [CW-1:0]   cpu_wdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [CW-1:0]   mem_wdata,
    input  logic [CW-1:0]   mem_rdata,
    output logic [CNTW-1:0] corr_count,
    output logic [CNTW-1:0] unc_count,
    output logic            unc_alert
);

    logic          cfg_en;
    logic [IW-1:0] cfg_pace;
    logic [AW-1:0] cfg_base;
    logic [AW-1:0] cfg_span;
    logic          rd_single;
    logic          rd_double;
    logic [DW-1:0] rd_data;
    logic          scrub_req;
    logic          scrub_we;
    logic [AW-1:0] scrub_addr;
    logic [DW-1:0] wb_data;
    logic [CW-1:0] wb_cw;

    scrub_cfg #(.AW(AW), .IW(IW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .cfg_en    (cfg_en),
        .cfg_pace  (cfg_pace),
        .cfg_base  (cfg_base),
        .cfg_span  (cfg_span)
    );

    scrub_secded #(.DW(DW)) u_codec (
        .enc_data   (wb_data),
        .enc_cw     (wb_cw),
        .dec_cw     (mem_rdata),
        .dec_data   (rd_data),
        .dec_single (rd_single),
        .dec_double (rd_double)
    );

    scrub_ctrl #(.DW(DW), .AW(AW), .IW(IW), .CNTW(CNTW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_en),
        .cfg_pace   (cfg_pace),
        .cfg_base   (cfg_base),
        .cfg_span   (cfg_span),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .rd_single  (rd_single),
        .rd_double  (rd_double),
        .rd_data    (rd_data),
        .scrub_req  (scrub_req),
        .scrub_we   (scrub_we),
        .scrub_addr (scrub_addr),
        .wb_data    (wb_data),
        .corr_count (corr_count),
        .unc_count  (unc_count),
        .unc_alert  (unc_alert)
    );

    // processor owns the port whenever it asks
    always_comb begin
        mem_req = cpu_req || scrub_req;
        if (cpu_req) begin
            mem_we    = cpu_we;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
        end else begin
            mem_we    = scrub_we;
            mem_addr  = scrub_addr;
            mem_wdata = wb_cw;
        end
    end

    AST_NO_SCRUB_WRITE_ON_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we) |-> !mem_we); // R5

endmodule

// File: tb/tb_mem_scrub_engine.sv
module tb_mem_scrub_engine;

    localparam int CMAX = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [9:0]  cpu_addr = '0;
    logic [21:0] cpu_wdata = '0;
    logic        mem_req, mem_we;
    logic [9:0]  mem_addr;
    logic [21:0] mem_wdata;
    logic [21:0] rdata = '0;
    logic [3:0]  corr_count, unc_count;
    logic        unc_alert;

    mem_scrub_engine #(.DW(16), .AW(10), .IW(16), .CNTW(4)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(rdata), .corr_count(corr_count), .unc_count(unc_count), .unc_alert(unc_alert)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int n_wr = 0;
    int n_alert = 0;
    int rd_t[$];
    int rd_a[$];
    logic [21:0] mem [1024];

    // ---------------- codec written from the requirement ----------------
    function automatic logic [21:0] b_enc(input logic [15:0] d);
        logic [21:0] w;
        int di;
        int s;
        w = '0;
        di = 0;
        for (int k = 1; k <= 21; k++) if ((k & (k - 1)) != 0) begin w[k] = d[di]; di++; end
        s = 0;
        for (int k = 1; k <= 21; k++) if (w[k]) s = s ^ k;
        for (int i = 0; i < 5; i++) w[1 << i] = s[i];
        w[0] = ^w[21:1];
        return w;
    endfunction

    task automatic b_dec(input logic [21:0] w, output logic [15:0] d, output bit sgl, output bit dbl);
        int s;
        bit ov;
        logic [21:0] f;
        int di;
        s = 0;
        for (int k = 1; k <= 21; k++) if (w[k]) s = s ^ k;
        ov = ^w;
        f = w;
        sgl = 0;
        dbl = 0;
        if (ov) begin
            if (s <= 21) begin sgl = 1; f[s] = ~f[s]; end
            else dbl = 1;
        end else if (s != 0) dbl = 1;
        d = '0;
        di = 0;
        for (int k = 1; k <= 21; k++) if ((k & (k - 1)) != 0) begin d[di] = f[k]; di++; end
    endtask

    function automatic logic [21:0] golden(input int a);
        return b_enc(16'(a * 945) ^ 16'hA5C3);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // ---------------- memory model ----------------
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] = mem_wdata;
            else        rdata <= mem[mem_addr];
        end
    end

    // ---------------- reference model ----------------
    int m_st, m_tmr, m_off, m_corr, m_unc, m_int, m_base, m_words;
    bit m_en, m_alert;
    logic [15:0] m_wb;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_tmr = 0; m_off = 0; m_corr = 0; m_unc = 0;
            m_int = 0; m_base = 0; m_words = 0; m_en = 0; m_alert = 0; m_wb = '0;
        end else begin
            int eff, last, addr;
            bit done, sgl, dbl;
            logic [15:0] d;
            eff  = (m_int == 0) ? 1 : m_int;
            last = (m_words == 0) ? 0 : m_words - 1;
            addr = (m_base + m_off) % 1024;
            done = 0;
            m_alert = 0;
            if (m_st == 0) begin
                if (!m_en) m_tmr = 0;
                else if (m_tmr + 1 >= eff) begin m_tmr = 0; m_st = 1; end
                else m_tmr++;
            end else if (m_st == 1) begin
                if (!cpu_req) m_st = 2;
            end else if (m_st == 2) begin
                b_dec(rdata, d, sgl, dbl);
                if (dbl) begin
                    if (m_unc < CMAX) m_unc++;
                    m_alert = 1;
                    done = 1;
                end else if (sgl) begin
                    if (m_corr < CMAX) m_corr++;
                    if (cpu_req && cpu_we && int'(cpu_addr) == addr) done = 1;
                    else begin m_wb = d; m_st = 3; end
                end else done = 1;
            end else begin
                if (!cpu_req || (cpu_we && int'(cpu_addr) == addr)) done = 1;
            end
            if (done) begin
                m_st = 0; m_tmr = 0;
                m_off = (m_off >= last) ? 0 : m_off + 1;
            end
            if (reg_we) begin
                case (reg_sel)
                    2'd0: m_en = reg_wdata[0];
                    2'd1: m_int = int'(reg_wdata);
                    2'd2: m_base = int'(reg_wdata[9:0]);
                    default: m_words = int'(reg_wdata[9:0]);
                endcase
            end
        end
    end

    // ---------------- per-cycle comparison and logging ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_req, e_we;
            int e_addr;
            e_req  = cpu_req || m_st == 1 || m_st == 3;
            e_we   = cpu_req ? cpu_we : (m_st == 3);
            e_addr = cpu_req ? int'(cpu_addr) : (m_base + m_off) % 1024;
            chk("R5", "mem_req", 32'(mem_req), 32'(e_req));
            if (e_req) begin
                chk("R7", "mem_we", 32'(mem_we), 32'(e_we));
                chk("R4", "mem_addr", 32'(mem_addr), 32'(e_addr));
                if (e_we) chk("R6", "mem_wdata", 32'(mem_wdata),
                              32'(cpu_req ? cpu_wdata : b_enc(m_wb)));
            end
            chk("R6", "corr_count", 32'(corr_count), 32'(m_corr));
            chk("R8", "unc_count", 32'(unc_count), 32'(m_unc));
            chk("R8", "unc_alert", 32'(unc_alert), 32'(m_alert));
            if (mem_req && !mem_we && !cpu_req) begin rd_t.push_back(cyc); rd_a.push_back(int'(mem_addr)); end
            if (mem_req && mem_we && !cpu_req) n_wr++;
            if (unc_alert) n_alert++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            report();
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [15:0] val);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic wait_scrub_read(input int a);
        do @(negedge clk); while (!(mem_req && !mem_we && !cpu_req && int'(mem_addr) == a));
    endtask

    initial begin
        logic [3:0] c0, u0;
        for (int a = 0; a < 1024; a++) mem[a] = golden(a);
        run(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset mem_req", 32'(mem_req), 0);
        chk("R1", "reset corr", 32'(corr_count), 0);
        chk("R1", "reset unc", 32'(unc_count), 0);
        chk("R1", "reset alert", 32'(unc_alert), 0);
        run(10);
        chk("R1", "disabled: no scrub reads", 32'(rd_t.size()), 0);

        // R3 / R4 / R7: pace 5 over window 16..19, clean memory
        wr_reg(2'd2, 16'd16);
        wr_reg(2'd3, 16'd4);
        wr_reg(2'd1, 16'd5);
        rd_t.delete(); rd_a.delete(); n_wr = 0;
        wr_reg(2'd0, 16'd1);
        run(60);
        chk("R3", "read count", 32'(rd_t.size() >= 6), 1);
        if (rd_t.size() >= 6) begin
            for (int i = 1; i < 6; i++) chk("R3", "read spacing", 32'(rd_t[i] - rd_t[i-1]), 7);
            for (int i = 0; i < 6; i++) chk("R4", "read address", 32'(rd_a[i]), 32'(16 + i % 4));
        end
        chk("R7", "no write on clean words", 32'(n_wr), 0);

        // R2: pace 0 acts as 1
        wr_reg(2'd1, 16'd0);
        run(5);
        rd_t.delete(); rd_a.delete();
        run(30);
        chk("R2", "read count pace 0", 32'(rd_t.size() >= 4), 1);
        for (int i = 1; i < rd_t.size(); i++) chk("R2", "pace 0 spacing", 32'(rd_t[i] - rd_t[i-1]), 3);

        // R6: single error repaired
        wr_reg(2'd1, 16'd3);
        c0 = corr_count;
        n_wr = 0;
        mem[17][5] = ~mem[17][5];
        run(40);
        chk("R6", "word repaired", 32'(mem[17]), 32'(golden(17)));
        chk("R6", "corrected count", 32'(corr_count), 32'(c0 + 4'd1));
        chk("R6", "one write-back", 32'(n_wr), 1);

        // R8: double error counted, alerted, left alone
        u0 = unc_count;
        mem[18] = mem[18] ^ 22'h18;
        n_alert = 0; n_wr = 0;
        wait_scrub_read(18);
        run(5);
        chk("R8", "alert pulses", 32'(n_alert), 1);
        chk("R8", "uncorrectable count", 32'(unc_count), 32'(u0 + 4'd1));
        chk("R8", "bad word untouched", 32'(mem[18]), 32'(golden(18) ^ 22'h18));
        chk("R8", "no write-back", 32'(n_wr), 0);
        mem[18] = golden(18);

        // R9: processor write in the data-return cycle cancels write-back
        mem[17][9] = ~mem[17][9];
        wait_scrub_read(17);
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 10'd17; cpu_wdata = b_enc(16'h1234);
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        run(30);
        chk("R9", "cpu data kept (wait cycle)", 32'(mem[17]), 32'(b_enc(16'h1234)));

        // R9: processor write while write-back pending
        mem[17][2] = ~mem[17][2];
        wait_scrub_read(17);
        @(posedge clk); #1;
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 10'd17; cpu_wdata = b_enc(16'hBEEF);
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        run(30);
        chk("R9", "cpu data kept (pending write)", 32'(mem[17]), 32'(b_enc(16'hBEEF)));
        mem[17] = golden(17);

        // R5 / R11: stalled read survives disable
        wr_reg(2'd1, 16'd1);
        run(10);
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 10'd500;
        run(8);
        wr_reg(2'd0, 16'd0);
        run(5);
        rd_t.delete();
        @(posedge clk); #1;
        cpu_req = 1'b0;
        run(40);
        chk("R11", "stalled step completes once", 32'(rd_t.size()), 1);
        chk("R5", "stalled read not dropped", 32'(rd_t.size() > 0), 1);

        // R10: corrected count saturates
        wr_reg(2'd0, 16'd1);
        for (int i = 0; i < 20; i++) begin
            mem[16 + i % 4][i % 22] = ~mem[16 + i % 4][i % 22];
            run(24);
        end
        chk("R10", "corrected count saturates", 32'(corr_count), 32'(CMAX));

        // mixed processor traffic, errors and contention, model compared every clock
        wr_reg(2'd1, 16'd2);
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            logic [21:0] w;
            r = $urandom;
            w = b_enc(r[31:16]);
            if (r[15]) w[r[20:16] % 22] = ~w[r[20:16] % 22];
            if (r[21] && r[22]) w = w ^ 22'h300;
            cpu_req   = (r[1:0] == 2'b00);
            cpu_we    = r[2];
            cpu_addr  = r[14] ? r[13:4] : 10'(16 + int'(r[4:3]));
            cpu_wdata = w;
            @(posedge clk); #1;
        end
        cpu_req = 1'b0; cpu_we = 1'b0;
        run(20);
        report();
        $finish;
    end

endmodule